// File: doc/BRIEF.md
# MAC Address Table Command Engine

This block gives a host a command-and-status path into a small table of MAC address entries. The host stages an entry in two 32-bit words and raises a make command. The engine then finds a slot for the entry by itself: a slot that already holds the same MAC address, otherwise the lowest empty slot. The same make command updates an entry that is already present, and it removes that entry when the staged valid flag is clear. While a make is running the host sees a pending flag, and it clears the command bit only after that flag drops.

To read the table, the host walks the valid entries with a cursor. A first command restarts the cursor at slot zero. A next command continues from the slot after the one last returned. Each search checks one slot per clock and holds a busy flag until it finishes. When the search finds a valid entry, that entry is loaded into two read-data words. When no valid slot remains, an end-of-table flag is raised and the read words are zeroed. The command bits are plain register bits that keep their value until software clears them. A command starts only when its bit goes from 0 to 1.

Top module: `mac_tbl_cmd_eng`

## Requirements
- R1: The command word uses bit 2 for make, bit 1 for get-first and bit 0 for get-next. Bits 31 to 3 always read as 0. After reset every output is 0.
- R2: A command bit keeps its written value until the host writes it again. A command starts only when a write takes its bit from 0 to 1. Writing 0, or writing 1 to a bit that is already 1, starts nothing.
- R3: Staged word 0 holds MAC[31:0]. Staged word 1 holds MAC[47:32] in bits 15:0, the port in bits 17:16, the static flag in bit 18 and the valid flag in bit 19. A make of a valid entry whose MAC is not in the table places it in the lowest empty slot.
- R4: A make of a valid entry whose MAC is already in the table overwrites that slot in place, so no duplicate is created. This also works when the table is full.
- R5: A make with the valid flag clear empties the slot that holds the matching MAC. If no slot matches, the table is not changed.
- R6: A make of a new valid MAC into a full table is dropped and sets the full-error flag. Each new make clears that flag when it starts.
- R7: make_pending rises on the clock edge that stores the rising make bit. It stays high for exactly DEPTH cycles, and the table change is visible when it falls.
- R8: Get-first searches from slot 0. It loads the first valid entry into the read words, using the R3 layout with the valid bit set. If that entry sits in slot s, busy stays high for s+1 cycles.
- R9: Get-next searches from the slot after the last returned entry. It returns the next valid entry, and busy stays high for s-c+1 cycles, where c is the slot where the search starts.
- R10: When no valid slot is left, the engine sets end-of-table, zeroes both read words and keeps busy high for DEPTH-c+1 cycles. Further get-next commands report end-of-table again. Finding an entry clears the flag.
- R11: A read command that rises while a search is busy is ignored. When first and next rise in the same write, first is carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word write data |
| cmd_rdata | output | 32 | Command word read back |
| stage_wr | input | 2 | Write strobes for staged words 0 and 1 |
| stage_wdata | input | 32 | Staged word write data |
| rd_word0 | output | 32 | Read entry, MAC[31:0] |
| rd_word1 | output | 32 | Read entry, upper MAC and flags (R3 layout) |
| make_pending | output | 1 | Make in progress |
| make_full_err | output | 1 | Last make was dropped because the table was full |
| rd_busy | output | 1 | Search in progress |
| rd_end | output | 1 | The last search found no valid entry |

## Verification
Make_pending and rd_busy are high in the cycle right after the write edge that stores a rising command bit. The bench samples 1 ns after each rising edge and counts how many sampled cycles each flag stays high. The expected counts are DEPTH for a make, s-c+1 for a search that finds an entry and DEPTH-c+1 for a search that runs off the end, all worked out from a bench-side table model. The read words, the end-of-table flag and the full-error flag are checked in the first sample where the flag is low, because they are updated on the same edge that clears it.

// File: rtl/mac_tbl_pkg.sv
package mac_tbl_pkg;

    localparam int MAC_W   = 48;
    localparam int PORT_W  = 2;
    localparam int WORD_W  = 32;
    localparam int CMD_W   = 3;

    localparam int CMD_NEXT_BIT  = 0;
    localparam int CMD_FIRST_BIT = 1;
    localparam int CMD_MAKE_BIT  = 2;

    typedef struct packed {
        logic               valid;
        logic               static_f;
        logic [PORT_W-1:0]  port;
        logic [MAC_W-1:0]   mac;
    } tbl_ent_t;

    localparam int ENT_W = $bits(tbl_ent_t);

    function automatic tbl_ent_t words_to_ent(input logic [WORD_W-1:0] w0,
                                              input logic [WORD_W-1:0] w1);
        tbl_ent_t e;
        e.mac      = {w1[15:0], w0};
        e.port     = w1[17:16];
        e.static_f = w1[18];
        e.valid    = w1[19];
        return e;
    endfunction

    function automatic logic [WORD_W-1:0] ent_lo_word(input tbl_ent_t e);
        return e.mac[31:0];
    endfunction

    function automatic logic [WORD_W-1:0] ent_hi_word(input tbl_ent_t e);
        return {12'd0, e.valid, e.static_f, e.port, e.mac[MAC_W-1:32]};
    endfunction

endpackage

// File: rtl/mac_tbl_store.sv
module mac_tbl_store
    import mac_tbl_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [IW-1:0]  wr_idx,
    input  tbl_ent_t       wr_ent,
    input  logic [IW-1:0]  rda_idx,
    output tbl_ent_t       rda_ent,
    input  logic [IW-1:0]  rdb_idx,
    output tbl_ent_t       rdb_ent
);

    tbl_ent_t slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (wr_en) begin
            slot_q[wr_idx] <= wr_ent;
        end
    end

    assign rda_ent = slot_q[rda_idx];
    assign rdb_ent = slot_q[rdb_idx];

endmodule

// File: rtl/mac_tbl_place.sv
module mac_tbl_place
    import mac_tbl_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  tbl_ent_t       new_ent,
    output logic [IW-1:0]  rd_idx,
    input  tbl_ent_t       rd_ent,
    output logic           wr_en,
    output logic [IW-1:0]  wr_idx,
    output tbl_ent_t       wr_ent,
    output logic           pending,
    output logic           full_err
);

    localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);

    logic          pending_q, full_err_q;
    logic [IW-1:0] idx_q, hit_idx_q, free_idx_q;
    logic          hit_q, free_q;
    tbl_ent_t      req_q;

    logic          cur_hit, cur_free, hit_n, free_n, last;
    logic [IW-1:0] hit_idx_n, free_idx_n;
    logic          unused_place;

    assign rd_idx     = idx_q;
    assign cur_hit    = rd_ent.valid && (rd_ent.mac == req_q.mac);
    assign cur_free   = !rd_ent.valid;
    assign hit_n      = hit_q  || cur_hit;
    assign free_n     = free_q || cur_free;
    assign hit_idx_n  = hit_q  ? hit_idx_q  : idx_q;
    assign free_idx_n = free_q ? free_idx_q : idx_q;
    assign last       = (idx_q == LAST_IDX);
    assign unused_place = ^{rd_ent.port, rd_ent.static_f};

    always_comb begin
        wr_en  = 1'b0;
        wr_idx = hit_n ? hit_idx_n : free_idx_n;
        wr_ent = req_q.valid ? req_q : '0;
        if (pending_q && last) begin
            if (req_q.valid) wr_en = hit_n || free_n;
            else             wr_en = hit_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q  <= 1'b0;
            full_err_q <= 1'b0;
            idx_q      <= '0;
            hit_q      <= 1'b0;
            free_q     <= 1'b0;
            hit_idx_q  <= '0;
            free_idx_q <= '0;
            req_q      <= '0;
        end else if (start && !pending_q) begin
            pending_q  <= 1'b1;
            full_err_q <= 1'b0;
            idx_q      <= '0;
            hit_q      <= 1'b0;
            free_q     <= 1'b0;
            req_q      <= new_ent;
        end else if (pending_q) begin
            hit_q      <= hit_n;
            free_q     <= free_n;
            hit_idx_q  <= hit_idx_n;
            free_idx_q <= free_idx_n;
            if (last) begin
                pending_q  <= 1'b0;
                full_err_q <= req_q.valid && !hit_n && !free_n;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign pending  = pending_q;
    assign full_err = full_err_q;

    assert_pending_holds_R7: assert property (@(posedge clk) disable iff (rst)
        pending_q && !last |=> pending_q);
    assert_pending_ends_R7: assert property (@(posedge clk) disable iff (rst)
        pending_q && last |=> !pending_q);
    assert_err_after_make_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(full_err_q) |-> !pending_q && $past(pending_q));
    assert_single_write_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

endmodule

// File: rtl/mac_tbl_walk.sv
module mac_tbl_walk
    import mac_tbl_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           go_first,
    input  logic           go_next,
    output logic [IW-1:0]  rd_idx,
    input  tbl_ent_t       rd_ent,
    output logic           busy,
    output logic           at_eot,
    output tbl_ent_t       out_ent
);

    localparam logic [IW:0] END_PTR = (IW+1)'(DEPTH);

    logic [IW:0] sp_q, nxt_q;
    logic        busy_q, eot_q;
    tbl_ent_t    out_q;
    logic        start, at_end;

    assign start  = (go_first || go_next) && !busy_q;
    assign at_end = (sp_q == END_PTR);
    assign rd_idx = sp_q[IW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q   <= '0;
            nxt_q  <= '0;
            busy_q <= 1'b0;
            eot_q  <= 1'b0;
            out_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            sp_q   <= go_first ? '0 : nxt_q;
        end else if (busy_q) begin
            if (at_end) begin
                busy_q <= 1'b0;
                eot_q  <= 1'b1;
                out_q  <= '0;
                nxt_q  <= END_PTR;
            end else if (rd_ent.valid) begin
                busy_q <= 1'b0;
                eot_q  <= 1'b0;
                out_q  <= rd_ent;
                nxt_q  <= sp_q + 1'b1;
            end else begin
                sp_q <= sp_q + 1'b1;
            end
        end
    end

    assign busy    = busy_q;
    assign at_eot  = eot_q;
    assign out_ent = out_q;

    assert_eot_zero_R10: assert property (@(posedge clk) disable iff (rst)
        eot_q && !busy_q |-> out_q == '0);
    assert_found_valid_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) && !eot_q |-> out_q.valid);
    assert_scan_step_R11: assert property (@(posedge clk) disable iff (rst)
        busy_q && !at_end && !rd_ent.valid |=> busy_q && sp_q == $past(sp_q) + 1'b1);
    assert_ptr_bound_R9: assert property (@(posedge clk) disable iff (rst)
        sp_q <= END_PTR && nxt_q <= END_PTR);

endmodule

// File: rtl/mac_tbl_cmd_eng.sv
module mac_tbl_cmd_eng
    import mac_tbl_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] cmd_rdata,
    input  logic [1:0]  stage_wr,
    input  logic [31:0] stage_wdata,
    output logic [31:0] rd_word0,
    output logic [31:0] rd_word1,
    output logic        make_pending,
    output logic        make_full_err,
    output logic        rd_busy,
    output logic        rd_end
);

    localparam int IW = $clog2(DEPTH);

    logic [CMD_W-1:0]  cmd_q;
    logic [CMD_W-1:0]  cmd_rise;
    logic [WORD_W-1:0] stage_q [2];
    logic              unused_rsvd;

    logic [IW-1:0] pl_rd_idx, wk_rd_idx, wr_idx;
    tbl_ent_t      pl_rd_ent, wk_rd_ent, wr_ent, walk_ent;
    logic          wr_en;

    assign unused_rsvd = ^cmd_wdata[WORD_W-1:CMD_W];
    assign cmd_rise    = cmd_wr ? (cmd_wdata[CMD_W-1:0] & ~cmd_q) : '0;

    always_ff @(posedge clk) begin
        if (rst)         cmd_q <= '0;
        else if (cmd_wr) cmd_q <= cmd_wdata[CMD_W-1:0];
    end

    for (genvar g = 0; g < 2; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)              stage_q[g] <= '0;
            else if (stage_wr[g]) stage_q[g] <= stage_wdata;
        end
    end

    mac_tbl_store #(.DEPTH(DEPTH)) store_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_ent  (wr_ent),
        .rda_idx (wk_rd_idx),
        .rda_ent (wk_rd_ent),
        .rdb_idx (pl_rd_idx),
        .rdb_ent (pl_rd_ent)
    );

    mac_tbl_place #(.DEPTH(DEPTH)) place_i (
        .clk      (clk),
        .rst      (rst),
        .start    (cmd_rise[CMD_MAKE_BIT]),
        .new_ent  (words_to_ent(stage_q[0], stage_q[1])),
        .rd_idx   (pl_rd_idx),
        .rd_ent   (pl_rd_ent),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_ent   (wr_ent),
        .pending  (make_pending),
        .full_err (make_full_err)
    );

    mac_tbl_walk #(.DEPTH(DEPTH)) walk_i (
        .clk      (clk),
        .rst      (rst),
        .go_first (cmd_rise[CMD_FIRST_BIT]),
        .go_next  (cmd_rise[CMD_NEXT_BIT]),
        .rd_idx   (wk_rd_idx),
        .rd_ent   (wk_rd_ent),
        .busy     (rd_busy),
        .at_eot   (rd_end),
        .out_ent  (walk_ent)
    );

    assign cmd_rdata = {{(WORD_W-CMD_W){1'b0}}, cmd_q};
    assign rd_word0  = ent_lo_word(walk_ent);
    assign rd_word1  = ent_hi_word(walk_ent);

    assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !cmd_wr |=> $stable(cmd_rdata));
    assert_make_start_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && cmd_wdata[CMD_MAKE_BIT] && !cmd_rdata[CMD_MAKE_BIT] && !make_pending
        |=> make_pending);
    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (rst)
        cmd_rdata[WORD_W-1:CMD_W] == '0);

endmodule

// File: tb/mac_tbl_cmd_eng_tb_top.sv
module mac_tbl_cmd_eng_tb_top;

    localparam int DEPTH = 16;
    localparam int POOL  = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic [1:0]  stage_wr = '0;
    logic [31:0] stage_wdata = '0;
    logic [31:0] rd_word0, rd_word1;
    logic        make_pending, make_full_err, rd_busy, rd_end;

    always #4 clk = ~clk;

    mac_tbl_cmd_eng #(.DEPTH(DEPTH)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .cmd_wr        (cmd_wr),
        .cmd_wdata     (cmd_wdata),
        .cmd_rdata     (cmd_rdata),
        .stage_wr      (stage_wr),
        .stage_wdata   (stage_wdata),
        .rd_word0      (rd_word0),
        .rd_word1      (rd_word1),
        .make_pending  (make_pending),
        .make_full_err (make_full_err),
        .rd_busy       (rd_busy),
        .rd_end        (rd_end)
    );

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;
    int  cur_nxt = 0;

    logic        m_valid [DEPTH];
    logic [47:0] m_mac   [DEPTH];
    logic [1:0]  m_port  [DEPTH];
    logic        m_stat  [DEPTH];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [47:0] pool_mac(input int i);
        return {16'h02A0 + 16'(i), 32'(i) * 32'h9E37_79B1};
    endfunction

    function automatic int m_match(input logic [47:0] mac);
        for (int i = 0; i < DEPTH; i++) if (m_valid[i] && m_mac[i] == mac) return i;
        return -1;
    endfunction

    function automatic int m_free();
        for (int i = 0; i < DEPTH; i++) if (!m_valid[i]) return i;
        return -1;
    endfunction

    function automatic int m_next_valid(input int st);
        for (int i = st; i < DEPTH; i++) if (m_valid[i]) return i;
        return DEPTH;
    endfunction

    task automatic wr_cmd(input logic [31:0] v);
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_wdata = v;
        @(posedge clk);
        #1;
        cmd_wr = 1'b0;
    endtask

    task automatic do_make(input logic [47:0] mac, input logic [1:0] port,
                           input logic st, input logic vld, input bit hold_chk);
        int  n = 0;
        int  hit, fr;
        bit  exp_err = 0;
        @(negedge clk);
        stage_wr = 2'b11;
        stage_wdata = mac[31:0];
        @(negedge clk);
        stage_wr = 2'b10;
        stage_wdata = {12'd0, vld, st, port, mac[47:32]};
        @(negedge clk);
        stage_wr = 2'b00;
        stage_wr[0] = 1'b0;
        hit = m_match(mac);
        fr  = m_free();
        if (vld) begin
            if (hit >= 0) begin
                m_port[hit] = port; m_stat[hit] = st;
            end else if (fr >= 0) begin
                m_valid[fr] = 1'b1; m_mac[fr] = mac; m_port[fr] = port; m_stat[fr] = st;
            end else begin
                exp_err = 1;
            end
        end else if (hit >= 0) begin
            m_valid[hit] = 1'b0;
        end
        wr_cmd(32'h4);
        while (make_pending && n < 1000) begin
            n++;
            @(posedge clk);
            #1;
        end
        chk("R7 make pending cycles", 64'(n), 64'(DEPTH));
        chk("R6 full error flag", 64'(make_full_err), 64'(exp_err));
        if (hold_chk) begin
            chk("R2 make bit held", 64'(cmd_rdata), 64'h4);
            wr_cmd(32'h4);
            chk("R2 rewrite of set bit starts nothing", 64'(make_pending), 64'd0);
        end
        wr_cmd(32'h0);
    endtask

    task automatic read_cmd(input logic [31:0] v, input string tag);
        int  n = 0;
        int  st, s;
        st = v[1] ? 0 : cur_nxt;
        s  = m_next_valid(st);
        wr_cmd(v);
        while (rd_busy && n < 1000) begin
            n++;
            @(posedge clk);
            #1;
        end
        if (s < DEPTH) begin
            chk({tag, " busy cycles"}, 64'(n), 64'(s - st + 1));
            chk({tag, " word0"}, 64'(rd_word0), 64'(m_mac[s][31:0]));
            chk({tag, " word1 R3 layout"}, 64'(rd_word1),
                64'({12'd0, 1'b1, m_stat[s], m_port[s], m_mac[s][47:32]}));
            chk({tag, " end flag clear R10"}, 64'(rd_end), 64'd0);
            cur_nxt = s + 1;
        end else begin
            chk({tag, " R10 busy cycles at end"}, 64'(n), 64'(DEPTH - st + 1));
            chk({tag, " R10 end flag"}, 64'(rd_end), 64'd1);
            chk({tag, " R10 words zero"}, {rd_word1, rd_word0}, 64'd0);
            cur_nxt = DEPTH;
        end
        wr_cmd(32'h0);
    endtask

    task automatic walk_all(input string tag);
        read_cmd(32'h2, {tag, " R8 first"});
        for (int k = 0; k < DEPTH + 1 && !rd_end; k++) read_cmd(32'h1, {tag, " R9 next"});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired R1 actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED_0042);
        for (int i = 0; i < DEPTH; i++) begin
            m_valid[i] = 0; m_mac[i] = '0; m_port[i] = '0; m_stat[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(posedge clk);
        #1;

        chk("R1 reset cmd word", 64'(cmd_rdata), 64'd0);
        chk("R1 reset read words", {rd_word1, rd_word0}, 64'd0);
        chk("R1 reset flags", 64'({make_pending, make_full_err, rd_busy, rd_end}), 64'd0);

        wr_cmd(32'hFFFF_FFF8);
        chk("R1 reserved bits read zero", 64'(cmd_rdata), 64'd0);
        chk("R2 zero command bits start nothing", 64'({make_pending, rd_busy}), 64'd0);

        walk_all("empty");

        begin
            int n = 0;
            wr_cmd(32'h2);
            wr_cmd(32'h3);
            while (rd_busy && n < 1000) begin
                n++;
                @(posedge clk);
                #1;
            end
            chk("R11 next during busy ignored, busy cycles", 64'(n + 1), 64'(DEPTH + 1));
            chk("R11 end reached once", 64'(rd_end), 64'd1);
            wr_cmd(32'h0);
            chk("R11 no late search", 64'(rd_busy), 64'd0);
            cur_nxt = DEPTH;
        end

        do_make(pool_mac(0), 2'd1, 1'b0, 1'b1, 1);
        do_make(pool_mac(1), 2'd2, 1'b1, 1'b1, 0);
        walk_all("R3 two inserts");
        do_make(pool_mac(0), 2'd3, 1'b1, 1'b1, 0);
        walk_all("R4 update in place");
        do_make(pool_mac(0), 2'd0, 1'b0, 1'b0, 0);
        read_cmd(32'h2, "R5 delete then R8 first");
        do_make(pool_mac(7), 2'd0, 1'b0, 1'b0, 0);
        walk_all("R5 delete of absent MAC");
        read_cmd(32'h3, "R11 first wins over next");

        for (int r = 0; r < 60; r++) begin
            int pi;
            logic vld;
            pi  = int'($urandom_range(POOL - 1));
            vld = ($urandom_range(3) != 0);
            do_make(pool_mac(pi), 2'($urandom_range(3)), 1'($urandom_range(1)), vld, 0);
            if (r % 10 == 9) walk_all("random walk");
        end

        for (int i = 0; i < DEPTH; i++)
            if (m_valid[i]) do_make(m_mac[i], 2'd0, 1'b0, 1'b0, 0);
        for (int i = 0; i < DEPTH; i++) do_make(pool_mac(100 + i), 2'(i), 1'b0, 1'b1, 0);
        do_make(pool_mac(200), 2'd1, 1'b0, 1'b1, 0);
        chk("R6 full table error set", 64'(make_full_err), 64'd1);
        do_make(pool_mac(105), 2'd2, 1'b1, 1'b1, 0);
        chk("R4 update when full, no error", 64'(make_full_err), 64'd0);
        walk_all("R6 full table walk");
        do_make(pool_mac(100), 2'd0, 1'b0, 1'b0, 0);
        do_make(pool_mac(200), 2'd3, 1'b0, 1'b1, 0);
        walk_all("R3 reuse lowest free slot");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule